// File: doc/BRIEF.md
# LIN Break Field Generator

This block drives the break field that opens every frame on a LIN-style single-wire bus, and then the break delimiter. The oversampling tick runs at eight times the bit rate. A start pulse begins a fixed window of 14 bit times. The transmit line is pulled dominant (low) for the first 13 bit times and released recessive (high) for the last one. When the window ends, a one-cycle terminal-count pulse tells the byte transmitter to send the sync byte 0x55.

A single tick counter times the whole window. Once the delimiter has begun, the line is held high by its own register, independent of the counter. No wrap or stop of the counter can then make a falling edge that slaves would take as the start bit of the sync byte. The counter does not free-run. It stops at terminal count and waits for the next start. An abort input, raised by readback logic that sees a bit error, ends the window at once without a terminal-count pulse. The generator is then ready for a fresh start.

Top module: `lin_brk_gen`

## Requirements
- R1: In reset and while idle, tx_o is 1 (recessive), busy_o is 0 and tc_o is 0. Reset applied in the middle of a break returns to this state.
- R2: A start_i pulse while idle gives busy_o = 1 and tx_o = 0 in the next cycle.
- R3: tx_o stays low for exactly OVS*BRK_BITS ticks (104 by default). It goes high in the cycle after the edge that samples the 104th tick_i.
- R4: The delimiter lasts OVS*DLM_BITS ticks (8 by default). In the cycle after the edge that samples the 112th tick since start, tc_o is 1 for exactly one cycle and busy_o is 0.
- R5: Once tx_o has risen during a window, it does not fall again until a new start is accepted. Ticks after terminal count leave tx_o high and create no further tc_o.
- R6: start_i while busy_o is 1 is ignored. The window keeps its original timing (104 low ticks, 8 delimiter ticks).
- R7: abort_i while busy_o is 1 gives busy_o = 0 and tx_o = 1 in the next cycle, with no tc_o. This holds in both the break and the delimiter.
- R8: abort_i while idle has no effect. The next start produces a full-length window.
- R9: Cycles without tick_i do not advance the window. Ticks while idle change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle tick at eight times the bit rate |
| start_i | input | 1 | Request to begin a break window |
| abort_i | input | 1 | Bit-error abort from readback logic |
| tx_o | output | 1 | Transmit line, 0 dominant, 1 recessive |
| busy_o | output | 1 | Window in progress |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The assertions assume that tick_i, start_i and abort_i are synchronous single-cycle strobes. They also assume tick_i is never asserted in back-to-back windows faster than the clock, so each tick is seen on exactly one edge. The bench drives every strobe at the falling clock edge for one cycle only. Its tick spacing ranges from every cycle to every seventh cycle, so both dense and sparse tick patterns are covered. The bench never raises start_i and abort_i together, which keeps each event's effect separate at the ports.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  typedef enum logic [1:0] {
    BRK_IDLE  = 2'd0,
    BRK_LOW   = 2'd1,
    BRK_DELIM = 2'd2
  } brk_state_e;
endpackage

// File: rtl/lin_brk_cnt.sv
module lin_brk_cnt #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lin_brk_fsm.sv
module lin_brk_fsm
  import lin_brk_pkg::*;
#(
  parameter int LOW_TICKS = 104,
  parameter int PERIOD    = 112,
  parameter int CW        = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          abort_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          adv_o,
  output logic          drive_low_o,
  output logic          release_o,
  output logic          busy_o,
  output logic          tc_o
);
  brk_state_e state_q, state_d;
  logic       tc_q;
  logic       last_low, last_all, accept, fin;

  assign last_low = (cnt_i == CW'(LOW_TICKS - 1));
  assign last_all = (cnt_i == CW'(PERIOD - 1));
  assign accept   = (state_q == BRK_IDLE) && start_i;
  assign fin      = (state_q == BRK_DELIM) && tick_i && last_all && !abort_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BRK_IDLE:  if (start_i) state_d = BRK_LOW;
      BRK_LOW: begin
        if (abort_i)                  state_d = BRK_IDLE;
        else if (tick_i && last_low)  state_d = BRK_DELIM;
      end
      BRK_DELIM: begin
        if (abort_i || fin) state_d = BRK_IDLE;
      end
      default: state_d = BRK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BRK_IDLE;
      tc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tc_q    <= fin;
    end
  end

  // counter halts on the final tick instead of wrapping
  assign adv_o       = tick_i && (state_q != BRK_IDLE) && !abort_i &&
                       !((state_q == BRK_DELIM) && last_all);
  assign clr_o       = accept;
  assign drive_low_o = accept;
  assign release_o   = ((state_q != BRK_IDLE) && abort_i) ||
                       ((state_q == BRK_LOW) && tick_i && last_low);
  assign busy_o      = (state_q != BRK_IDLE);
  assign tc_o        = tc_q;
endmodule

// File: rtl/lin_brk_line.sv
module lin_brk_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_low_i,
  input  logic release_i,
  output logic tx_o
);
  logic tx_q;

  // line held by its own flop; only an accepted start may pull it low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tx_q <= 1'b1;
    else if (drive_low_i) tx_q <= 1'b0;
    else if (release_i)   tx_q <= 1'b1;
  end

  assign tx_o = tx_q;
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen #(
  parameter int OVS      = 8,
  parameter int BRK_BITS = 13,
  parameter int DLM_BITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  output logic tx_o,
  output logic busy_o,
  output logic tc_o
);
  localparam int LOW_TICKS = OVS * BRK_BITS;
  localparam int PERIOD    = OVS * (BRK_BITS + DLM_BITS);
  localparam int CW        = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  logic          clr, adv, drive_low, release_line;

  lin_brk_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .cnt_o  (cnt)
  );

  lin_brk_fsm #(
    .LOW_TICKS(LOW_TICKS),
    .PERIOD   (PERIOD),
    .CW       (CW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .abort_i     (abort_i),
    .cnt_i       (cnt),
    .clr_o       (clr),
    .adv_o       (adv),
    .drive_low_o (drive_low),
    .release_o   (release_line),
    .busy_o      (busy_o),
    .tc_o        (tc_o)
  );

  lin_brk_line u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_low_i (drive_low),
    .release_i   (release_line),
    .tx_o        (tx_o)
  );
endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic abort_i,
  input logic tx_o,
  input logic busy_o,
  input logic tc_o
);
  // R1
  a_r1_idle_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  // R2
  a_r2_start_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !tx_o));

  // R4
  a_r4_tc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);

  a_r4_tc_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (!busy_o && tx_o && $past(busy_o)));

  // R5
  a_r5_no_false_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o && busy_o) |=> tx_o);

  // R7
  a_r7_abort_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> (!busy_o && tx_o && !tc_o));

  // R9
  a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !abort_i) |=> ($stable(tx_o) && busy_o && !tc_o));
endmodule

bind lin_brk_gen lin_brk_chk u_chk (.*);

// File: tb/sim_lin_brk_gen.sv
module sim_lin_brk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int EXP_LOW    = 104;
  localparam int EXP_DLM    = 8;
  // vectors: {tick gap, start-injection tick index (-1 none), expected low, expected delimiter}
  localparam int NVEC = 5;
  localparam int VEC [NVEC][4] = '{
    '{1, -1, EXP_LOW, EXP_DLM},
    '{2, -1, EXP_LOW, EXP_DLM},
    '{3, 50, EXP_LOW, EXP_DLM},
    '{7, -1, EXP_LOW, EXP_DLM},
    '{4, 106, EXP_LOW, EXP_DLM}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, start_i = 1'b0, abort_i = 1'b0;
  logic tx_o, busy_o, tc_o;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  logic last_tc;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_brk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .abort_i(abort_i), .tx_o(tx_o), .busy_o(busy_o), .tc_o(tc_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick(int gap);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    last_tc = tc_o;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic strobe_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic strobe_abort();
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  task automatic run_break(input int gap, input int dup_at,
                           output int low_n, output int dlm_n,
                           output int tc_n, output int falls);
    int n = 0;
    bit was_low;
    low_n = 0; dlm_n = 0; tc_n = 0; falls = 0;
    strobe_start();
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 tx low after start", int'(tx_o), 0);
    while (busy_o && n < 300) begin
      if (n == dup_at) begin
        strobe_start();
      end
      was_low = !tx_o;
      pulse_tick(gap);
      n++;
      if (was_low) low_n++; else dlm_n++;
      if (!was_low && !tx_o) falls++;
      if (last_tc) tc_n++;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int low_n, dlm_n, tc_n, falls;
    @(negedge clk);
    chk("R1 reset tx", int'(tx_o), 1);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset tc", int'(tc_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      run_break(VEC[v][0], VEC[v][1], low_n, dlm_n, tc_n, falls);
      chk(VEC[v][1] >= 0 ? "R6 low ticks with busy start" : "R3 low ticks", low_n, VEC[v][2]);
      chk(VEC[v][1] >= 0 ? "R6 delim ticks with busy start" : "R4 delim ticks", dlm_n, VEC[v][3]);
      chk("R4 one tc pulse", tc_n, 1);
      chk("R5 no fall in delimiter", falls, 0);
      chk("R4 idle after tc", int'(busy_o), 0);
      @(negedge clk);
      chk("R4 tc single cycle", int'(tc_o), 0);
    end

    // R5 and R9: ticks after terminal count change nothing
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        pulse_tick(2);
        if (!tx_o || busy_o || tc_o) bad++;
      end
      chk("R5 R9 idle ticks no effect", bad, 0);
    end

    // R9: no tick means no progress
    strobe_start();
    repeat (300) @(negedge clk);
    chk("R9 no tick holds low", int'(tx_o), 0);
    chk("R9 no tick holds busy", int'(busy_o), 1);

    // R7: abort in break
    for (int i = 0; i < 20; i++) pulse_tick(1);
    strobe_abort();
    chk("R7 abort in break busy", int'(busy_o), 0);
    chk("R7 abort in break tx", int'(tx_o), 1);
    chk("R7 abort in break tc", int'(tc_o), 0);
    begin
      int bad = 0;
      for (int i = 0; i < 120; i++) begin
        pulse_tick(1);
        if (!tx_o || busy_o || tc_o) bad++;
      end
      chk("R7 stays idle after abort", bad, 0);
    end

    // R7: abort in delimiter
    strobe_start();
    for (int i = 0; i < 106; i++) pulse_tick(1);
    chk("R3 delimiter reached", int'(tx_o), 1);
    strobe_abort();
    chk("R7 abort in delim busy", int'(busy_o), 0);
    chk("R7 abort in delim tx", int'(tx_o), 1);
    @(negedge clk);
    chk("R7 abort in delim no tc", int'(tc_o), 0);

    // R8: abort while idle, then full window
    strobe_abort();
    chk("R8 idle abort tx", int'(tx_o), 1);
    chk("R8 idle abort busy", int'(busy_o), 0);
    run_break(1, -1, low_n, dlm_n, tc_n, falls);
    chk("R8 full low after idle abort", low_n, EXP_LOW);
    chk("R8 full delim after idle abort", dlm_n, EXP_DLM);

    // R1: reset in the middle of a break
    @(negedge clk);
    strobe_start();
    for (int i = 0; i < 30; i++) pulse_tick(1);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 mid reset tx", int'(tx_o), 1);
    chk("R1 mid reset busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run_break(1, -1, low_n, dlm_n, tc_n, falls);
    chk("R1 full low after reset", low_n, EXP_LOW);
    chk("R1 tc after reset", tc_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule